// File: doc/BRIEF.md
# Packet Page Segmenter with Header Splice

This block takes a byte stream of packets, framed by start and end markers, and cuts each packet into fixed-size pages. Every page goes into a bounded circular page store. The first page of each packet carries the packet header. That page is also offered on a header-processing port so that an external processor can rewrite it.

The processor sends the rewritten page back on a return channel. It replaces the stored first page in place, and the packet's pages are then released toward the fabric as a page stream with first and last flags. The return channel can also condemn a packet. In that case all of its pages are freed and none of them leave the block.

A packet's pages stay parked behind its header page until the rewrite comes back. Rewrites must come back in the same order the headers were sent.

Top module: `pg_segmenter`

## Requirements
- R1: A page holds PAGE_BYTES bytes, packed little-endian: packet byte k of a page sits at page bits [8k+7:8k]. The byte accepted with `in_sop` is the first byte of a packet.
- R2: A page that is not a packet's last page carries PAGE_BYTES valid bytes. A packet's last page carries its valid-byte count (1 to PAGE_BYTES) in the bytes field, and all bytes above that count are zero.
- R3: Only the first page of each packet appears on the header port, one per packet and in packet order, with its valid-byte count. `hdr_page` stays stable while `hdr_valid` is high and `hdr_ready` is low.
- R4: On the output, the first page of a packet equals the page accepted on the return channel for that packet. Its byte count is the one the page had originally.
- R5: Forwarded packets leave in arrival order and their pages leave in order. `out_first` marks the first page and `out_last` marks the last page; a one-page packet carries both flags.
- R6: No page of a packet is emitted before its rewritten header page has been accepted on the return channel.
- R7: Returns are matched to sent headers in send order. `ret_ready` is low whenever no sent header is still awaiting its return.
- R8: `in_ready` is low exactly while the page store holds NUM_PAGES pages, so at most NUM_PAGES*PAGE_BYTES bytes can be accepted while nothing drains.
- R9: A return accepted with `ret_drop` high frees every page of that packet. None of its pages is emitted, and the following packets still come out.
- R10: After reset, `in_ready` is high and `hdr_valid`, `ret_ready` and `out_valid` are low.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_page` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Packet byte |
| hdr_valid | output | 1 | Header page offered for processing |
| hdr_ready | input | 1 | Processor takes the header page |
| hdr_page | output | PAGE_BYTES*8 | Header page contents |
| hdr_bytes | output | $clog2(PAGE_BYTES+1) | Valid bytes in the header page |
| ret_valid | input | 1 | Rewritten header page offered |
| ret_ready | output | 1 | Block accepts the rewritten page |
| ret_page | input | PAGE_BYTES*8 | Rewritten header page |
| ret_drop | input | 1 | Discard this packet |
| out_valid | output | 1 | Output page valid |
| out_ready | input | 1 | Downstream takes the page |
| out_page | output | PAGE_BYTES*8 | Output page contents |
| out_bytes | output | $clog2(PAGE_BYTES+1) | Valid bytes in the output page |
| out_first | output | 1 | First page of a packet |
| out_last | output | 1 | Last page of a packet |

## Verification
Several events can land on the page store in the same cycle. A page can be committed from the input, a rewritten header can be spliced into an older slot, and the head page can be popped toward the output. The bench provokes these collisions by running random ready and valid patterns on the header, return and output ports while packets of every length from one byte to just over three pages stream in. It judges them by comparing each emitted page, its flags and its byte count against pages computed arithmetically from the packet number and byte index. A separate phase fills the store with the header held back, to confirm that input stalls after exactly NUM_PAGES pages and that no output appears before the splice.

// File: rtl/pg_seg_pkg.sv
// Package: shared types and helpers for the page segmenter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package pg_seg_pkg;

    // Emitter mode: forwarding pages, or silently draining a discarded packet.
    typedef enum logic {
        EM_PASS = 1'b0,
        EM_DROP = 1'b1
    } emit_state_e;

    // Advance a circular index that runs from 0 to last.
    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned last);
        return (idx == last) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/pg_idx_fifo.sv
// Small FIFO of slot indices.
// Used twice: once for header pages waiting to be sent, once for headers
// waiting for their rewritten return. Assumes the caller never pushes when
// full and never pops when empty.
module pg_idx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    import pg_seg_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign head  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // Store the pushed index.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_val;
    end

    // Move the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= PW'(wrap_inc(int'(wp), DEPTH - 1));
            if (pop)  rp <= PW'(wrap_inc(int'(rp), DEPTH - 1));
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_fifo_push_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    p_fifo_pop_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pg_assembler.sv
// Byte-to-page assembler.
// Gathers input bytes little-endian into a page register and commits the page
// when it is full or when the packet ends. Unused upper bytes of a short page
// are zero because the register clears after each commit. Assumes in_sop
// comes on the first byte of each packet and only there.
module pg_assembler #(
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_BITS  = PAGE_BYTES * 8,
    parameter int IDX_W      = $clog2(PAGE_BYTES),
    parameter int CNT_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_ready,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic [7:0]           in_data,
    output logic                 commit,
    output logic [PAGE_BITS-1:0] c_data,
    output logic [CNT_W-1:0]     c_bytes,
    output logic                 c_first,
    output logic                 c_last
);
    logic [PAGE_BITS-1:0] acc_q;
    logic [IDX_W-1:0]     pos_q;
    logic                 at_start_q;
    logic                 accept;

    assign accept = in_valid && in_ready;

    // Merge the incoming byte into the page at its byte lane.
    always_comb begin
        c_data  = acc_q | (PAGE_BITS'(in_data) << {pos_q, 3'b000});
        c_bytes = CNT_W'(pos_q) + 1'b1;
        c_first = at_start_q;
        c_last  = in_eop;
        commit  = accept && ((pos_q == IDX_W'(PAGE_BYTES - 1)) || in_eop);
    end

    // Advance the lane index, clear after commit, track the packet start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            pos_q      <= '0;
            at_start_q <= 1'b1;
        end else if (accept) begin
            if (commit) begin
                acc_q      <= '0;
                pos_q      <= '0;
                at_start_q <= in_eop;
            end else begin
                acc_q <= c_data;
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    p_sop_framing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (in_sop == (at_start_q && (pos_q == '0))));

endmodule

// File: rtl/pg_ring.sv
// Circular page store.
// Pages are written at the tail in arrival order and leave from the head in
// the same order. Each slot keeps its data, valid-byte count, first and last
// flags, plus a released flag and a drop flag set by a header splice.
// Assumes push never happens when full, pop never when empty, and a splice
// only targets an occupied, unreleased first page.
module pg_ring #(
    parameter int NUM_PAGES = 8,
    parameter int PAGE_BITS = 512,
    parameter int CNT_W     = 7,
    parameter int SLOT_W    = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [PAGE_BITS-1:0] push_data,
    input  logic [CNT_W-1:0]     push_bytes,
    input  logic                 push_first,
    input  logic                 push_last,
    output logic [SLOT_W-1:0]    wr_slot,
    output logic                 full,
    output logic                 empty,
    input  logic                 upd_en,
    input  logic [SLOT_W-1:0]    upd_slot,
    input  logic [PAGE_BITS-1:0] upd_data,
    input  logic                 upd_drop,
    input  logic                 pop,
    output logic [PAGE_BITS-1:0] head_data,
    output logic [CNT_W-1:0]     head_bytes,
    output logic                 head_first,
    output logic                 head_last,
    output logic                 head_rel,
    output logic                 head_drop,
    input  logic [SLOT_W-1:0]    peek_slot,
    output logic [PAGE_BITS-1:0] peek_data,
    output logic [CNT_W-1:0]     peek_bytes
);
    import pg_seg_pkg::*;

    localparam int OCC_W = $clog2(NUM_PAGES + 1);

    logic [PAGE_BITS-1:0] data_a  [NUM_PAGES];
    logic [CNT_W-1:0]     bytes_a [NUM_PAGES];
    logic                 first_a [NUM_PAGES];
    logic                 last_a  [NUM_PAGES];
    logic                 rel_a   [NUM_PAGES];
    logic                 drop_a  [NUM_PAGES];

    logic [SLOT_W-1:0] wr_q, rd_q;
    logic [OCC_W-1:0]  occ_q;

    for (genvar s = 0; s < NUM_PAGES; s++) begin : g_slot
        logic [PAGE_BITS-1:0] d_q;
        logic [CNT_W-1:0]     b_q;
        logic                 f_q, l_q, r_q, x_q;

        // Slot write: new page from the assembler, or a header splice.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= 1'b0;
                x_q <= 1'b0;
            end else if (push && (wr_q == SLOT_W'(s))) begin
                d_q <= push_data;
                b_q <= push_bytes;
                f_q <= push_first;
                l_q <= push_last;
                r_q <= 1'b0;
                x_q <= 1'b0;
            end else if (upd_en && (upd_slot == SLOT_W'(s))) begin
                d_q <= upd_data;
                r_q <= 1'b1;
                x_q <= upd_drop;
            end
        end

        assign data_a[s]  = d_q;
        assign bytes_a[s] = b_q;
        assign first_a[s] = f_q;
        assign last_a[s]  = l_q;
        assign rel_a[s]   = r_q;
        assign drop_a[s]  = x_q;
    end

    assign wr_slot    = wr_q;
    assign full       = (occ_q == OCC_W'(NUM_PAGES));
    assign empty      = (occ_q == '0);
    assign head_data  = data_a[rd_q];
    assign head_bytes = bytes_a[rd_q];
    assign head_first = first_a[rd_q];
    assign head_last  = last_a[rd_q];
    assign head_rel   = rel_a[rd_q];
    assign head_drop  = drop_a[rd_q];
    assign peek_data  = data_a[peek_slot];
    assign peek_bytes = bytes_a[peek_slot];

    // Tail, head and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) wr_q <= SLOT_W'(wrap_inc(int'(wr_q), NUM_PAGES - 1));
            if (pop)  rd_q <= SLOT_W'(wrap_inc(int'(rd_q), NUM_PAGES - 1));
            case ({push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_pop_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_first) |-> head_rel);
    p_splice_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (first_a[upd_slot] && !rel_a[upd_slot] && !empty));

endmodule

// File: rtl/pg_emit_ctrl.sv
// Output emitter.
// Looks at the head page of the store. A first page waits until its splice
// has arrived. A forwarded page is offered until downstream takes it. A packet
// marked for discard is drained one page per cycle with nothing offered.
// Assumes the head flags come from the page store and are stable while no pop
// happens.
module pg_emit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_first,
    input  logic head_last,
    input  logic head_rel,
    input  logic head_drop,
    input  logic out_ready,
    output logic out_valid,
    output logic pop
);
    import pg_seg_pkg::*;

    emit_state_e st_q, st_n;

    // Decide whether to offer, drain or wait on the head page.
    always_comb begin
        out_valid = 1'b0;
        pop       = 1'b0;
        st_n      = st_q;
        case (st_q)
            EM_DROP: begin
                if (head_valid) begin
                    pop = 1'b1;
                    if (head_last) st_n = EM_PASS;
                end
            end
            default: begin
                if (head_valid && (!head_first || head_rel)) begin
                    if (head_first && head_drop) begin
                        pop = 1'b1;
                        if (!head_last) st_n = EM_DROP;
                    end else begin
                        out_valid = 1'b1;
                        pop       = out_ready;
                    end
                end
            end
        endcase
    end

    // Hold the emitter mode.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EM_PASS;
        else        st_q <= st_n;
    end

    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    p_drain_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EM_DROP) |-> !out_valid);

endmodule

// File: rtl/pg_segmenter.sv
// Top: packet page segmenter with header splice.
// Input bytes become pages in the store. Each first page is queued for the
// header port. Once sent, its slot waits in a second queue for the rewritten
// page, which is spliced into the same slot. The emitter then releases or
// discards the packet. Assumes returns come back in send order.
module pg_segmenter #(
    parameter int PAGE_BYTES = 64,
    parameter int NUM_PAGES  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          in_sop,
    input  logic                          in_eop,
    input  logic [7:0]                    in_data,
    output logic                          hdr_valid,
    input  logic                          hdr_ready,
    output logic [PAGE_BYTES*8-1:0]       hdr_page,
    output logic [$clog2(PAGE_BYTES+1)-1:0] hdr_bytes,
    input  logic                          ret_valid,
    output logic                          ret_ready,
    input  logic [PAGE_BYTES*8-1:0]       ret_page,
    input  logic                          ret_drop,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [PAGE_BYTES*8-1:0]       out_page,
    output logic [$clog2(PAGE_BYTES+1)-1:0] out_bytes,
    output logic                          out_first,
    output logic                          out_last
);
    localparam int PAGE_BITS = PAGE_BYTES * 8;
    localparam int IDX_W     = $clog2(PAGE_BYTES);
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1);
    localparam int SLOT_W    = $clog2(NUM_PAGES);

    logic                 commit, c_first, c_last;
    logic [PAGE_BITS-1:0] c_data;
    logic [CNT_W-1:0]     c_bytes;
    logic [SLOT_W-1:0]    wr_slot, send_head, wait_head;
    logic                 ring_full, ring_empty;
    logic                 send_empty, send_full, wait_empty, wait_full;
    logic                 hdr_fire, ret_fire, pop;
    logic                 head_rel, head_drop;

    assign in_ready  = !ring_full;
    assign hdr_valid = !send_empty;
    assign hdr_fire  = hdr_valid && hdr_ready;
    assign ret_ready = !wait_empty;
    assign ret_fire  = ret_valid && ret_ready;

    pg_assembler #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_BITS  (PAGE_BITS),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_data  (in_data),
        .commit   (commit),
        .c_data   (c_data),
        .c_bytes  (c_bytes),
        .c_first  (c_first),
        .c_last   (c_last)
    );

    pg_ring #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_BITS (PAGE_BITS),
        .CNT_W     (CNT_W),
        .SLOT_W    (SLOT_W)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (commit),
        .push_data  (c_data),
        .push_bytes (c_bytes),
        .push_first (c_first),
        .push_last  (c_last),
        .wr_slot    (wr_slot),
        .full       (ring_full),
        .empty      (ring_empty),
        .upd_en     (ret_fire),
        .upd_slot   (wait_head),
        .upd_data   (ret_page),
        .upd_drop   (ret_drop),
        .pop        (pop),
        .head_data  (out_page),
        .head_bytes (out_bytes),
        .head_first (out_first),
        .head_last  (out_last),
        .head_rel   (head_rel),
        .head_drop  (head_drop),
        .peek_slot  (send_head),
        .peek_data  (hdr_page),
        .peek_bytes (hdr_bytes)
    );

    pg_idx_fifo #(
        .DEPTH (NUM_PAGES),
        .W     (SLOT_W)
    ) u_send_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (commit && c_first),
        .push_val (wr_slot),
        .pop      (hdr_fire),
        .head     (send_head),
        .empty    (send_empty),
        .full     (send_full)
    );

    pg_idx_fifo #(
        .DEPTH (NUM_PAGES),
        .W     (SLOT_W)
    ) u_wait_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (hdr_fire),
        .push_val (send_head),
        .pop      (ret_fire),
        .head     (wait_head),
        .empty    (wait_empty),
        .full     (wait_full)
    );

    pg_emit_ctrl u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!ring_empty),
        .head_first (out_first),
        .head_last  (out_last),
        .head_rel   (head_rel),
        .head_drop  (head_drop),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .pop        (pop)
    );

    // Mask of the byte lanes above the valid count of the output page.
    logic [PAGE_BITS-1:0] pad_mask;
    always_comb begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
            pad_mask[b*8 +: 8] = (b >= int'(out_bytes)) ? 8'hFF : 8'h00;
        end
    end

    p_hdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_page)));
    p_full_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_bytes == CNT_W'(PAGE_BYTES)));
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_first) |-> ((out_page & pad_mask) == '0));
    p_page_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_page));
    p_queue_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && c_first) |-> !send_full);

endmodule

// File: tb/pg_segmenter_tb.sv
// Bench for the page segmenter: small pages, every packet length up to just
// over three pages, random handshakes, expected pages computed arithmetically.
module pg_segmenter_tb;
    localparam int PB   = 8;
    localparam int NP   = 4;
    localparam int PBIT = PB * 8;
    localparam int CW   = $clog2(PB + 1);
    localparam int NPK  = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]      in_data = '0;
    logic            in_ready;
    logic            hdr_valid, hdr_ready = 1'b0;
    logic [PBIT-1:0] hdr_page;
    logic [CW-1:0]   hdr_bytes;
    logic            ret_valid = 1'b0, ret_ready, ret_drop = 1'b0;
    logic [PBIT-1:0] ret_page = '0;
    logic            out_valid, out_ready = 1'b0;
    logic [PBIT-1:0] out_page;
    logic [CW-1:0]   out_bytes;
    logic            out_first, out_last;

    int n_chk = 0, n_fail = 0;
    int pkt_len [NPK];
    bit hdr_en = 0, out_en = 0, done = 0;
    int out_cnt = 0, exp_total = 0;

    always #2 clk = ~clk;

    pg_segmenter #(.PAGE_BYTES(PB), .NUM_PAGES(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_page(hdr_page), .hdr_bytes(hdr_bytes),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_page(ret_page), .ret_drop(ret_drop),
        .out_valid(out_valid), .out_ready(out_ready), .out_page(out_page), .out_bytes(out_bytes),
        .out_first(out_first), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input logic [PBIT-1:0] act, input logic [PBIT-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_drop(input int id);
        return (id % 4) == 2;
    endfunction

    function automatic logic [7:0] byte_of(input int id, input int i);
        return 8'((id * 37 + i * 11 + 1) & 255);
    endfunction

    function automatic int npages(input int id);
        return (pkt_len[id] + PB - 1) / PB;
    endfunction

    function automatic int bytes_of(input int id, input int pg);
        int rest = pkt_len[id] - pg * PB;
        return (rest > PB) ? PB : rest;
    endfunction

    // Expected page: little-endian lanes, zero padding, optional rewrite pattern.
    function automatic logic [PBIT-1:0] page_of(input int id, input int pg, input bit rw);
        logic [PBIT-1:0] p = '0;
        for (int b = 0; b < PB; b++) begin
            int k = pg * PB + b;
            if (k < pkt_len[id]) p[b*8 +: 8] = byte_of(id, k) ^ (rw ? 8'hA5 : 8'h00);
        end
        return p;
    endfunction

    // Header processor model: takes headers, returns rewritten pages in order.
    initial begin : hdr_model
        int rq[$];
        int hid = 0;
        forever begin
            @(negedge clk);
            if (rst_n && rq.size() == 0)
                chk(ret_ready == 1'b0, "R7 ret_ready with nothing outstanding", PBIT'(ret_ready), '0);
            hdr_ready = hdr_en && ($urandom % 4 != 0);
            if (hdr_valid && hdr_ready) begin
                chk(hdr_page == page_of(hid, 0, 0), "R3 header page", hdr_page, page_of(hid, 0, 0));
                chk(int'(hdr_bytes) == bytes_of(hid, 0), "R3 header byte count", PBIT'(hdr_bytes), PBIT'(bytes_of(hid, 0)));
                rq.push_back(hid);
                hid++;
            end
            if (hdr_en && rq.size() > 0 && ($urandom % 3 != 0)) begin
                ret_valid = 1'b1;
                ret_page  = page_of(rq[0], 0, 1);
                ret_drop  = is_drop(rq[0]);
                if (ret_ready) void'(rq.pop_front());
            end else begin
                ret_valid = 1'b0;
            end
        end
    end

    // Output checker: pages, flags, counts, hold behaviour.
    initial begin : out_model
        int oid = 0, opg = 0;
        bit hold = 0;
        logic [PBIT-1:0] held = '0;
        forever begin
            @(negedge clk);
            out_ready = out_en && ($urandom % 3 != 0);
            if (hold) begin
                chk(out_valid && out_page == held, "R11 stalled page held", out_page, held);
                hold = 0;
            end
            if (out_valid) begin
                if (!out_ready) begin
                    hold = 1;
                    held = out_page;
                end else begin
                    logic [PBIT-1:0] ep;
                    while (oid < NPK && is_drop(oid)) oid++;
                    ep = page_of(oid, opg, opg == 0);
                    if (opg == 0) chk(out_page == ep, "R4 spliced first page", out_page, ep);
                    else          chk(out_page == ep, "R1 body page lanes", out_page, ep);
                    chk(int'(out_bytes) == bytes_of(oid, opg), "R2 valid byte count",
                        PBIT'(out_bytes), PBIT'(bytes_of(oid, opg)));
                    chk(out_first == (opg == 0) && out_last == (opg == npages(oid) - 1),
                        "R5 first/last flags", PBIT'({out_first, out_last}),
                        PBIT'({opg == 0, opg == npages(oid) - 1}));
                    out_cnt++;
                    if (opg == npages(oid) - 1) begin
                        oid++;
                        opg = 0;
                    end else begin
                        opg++;
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d pages", out_cnt, exp_total);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        pkt_len[0] = NP * PB + 3;
        for (int i = 1; i < NPK; i++) pkt_len[i] = i;
        for (int i = 0; i < NPK; i++) if (!is_drop(i)) exp_total += npages(i);

        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && hdr_valid == 1'b0 && ret_ready == 1'b0 && out_valid == 1'b0,
            "R10 reset state", PBIT'({in_ready, hdr_valid, ret_ready, out_valid}), PBIT'(4'b1000));
        rst_n = 1'b1;
        @(negedge clk);

        for (int id = 0; id < NPK; id++) begin
            bit stalled = 0;
            for (int i = 0; i < pkt_len[id]; i++) begin
                bit ok;
                in_valid = 1'b1;
                in_data  = byte_of(id, i);
                in_sop   = (i == 0);
                in_eop   = (i == pkt_len[id] - 1);
                forever begin
                    ok = in_ready;
                    if (id == 0 && !ok && !stalled) begin
                        stalled = 1;
                        chk(i == NP * PB, "R8 bytes accepted before stall", PBIT'(i), PBIT'(NP * PB));
                        chk(out_valid == 1'b0, "R6 no output before splice", PBIT'(out_valid), '0);
                        chk(hdr_valid == 1'b1, "R3 header offered", PBIT'(hdr_valid), PBIT'(1));
                        hdr_en = 1;
                        out_en = 1;
                    end
                    @(negedge clk);
                    if (ok) break;
                end
            end
            in_valid = 1'b0;
            in_sop   = 1'b0;
            in_eop   = 1'b0;
            if (id % 3 == 0) @(negedge clk);
        end

        while (out_cnt < exp_total) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(out_cnt == exp_total, "R9 only kept packets emitted", PBIT'(out_cnt), PBIT'(exp_total));
        chk(in_ready && !out_valid && !hdr_valid && !ret_ready, "R9 store freed after drops",
            PBIT'({in_ready, out_valid, hdr_valid, ret_ready}), PBIT'(4'b1000));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule